// File: doc/BRIEF.md
# Dual-Mode Host Register Port

This block is the host side of a register file. An 8-bit microprocessor reaches four identical register banks through it. Two static straps set how the pins are read. One strap picks the strobe style: separate active-low read and write strobes, or a single active-low data strobe with a read/write-bar level. The other strap picks the bus layout: a shared address/data bus demultiplexed by an address latch enable, or separate address and data buses. Each bank has its own active-low chip select. An access counts only when exactly one select is low.

All host pins pass through a two-stage synchronizer into the system clock before they are decoded. A state machine turns each access into one internal read strobe or one internal write strobe, together with the captured address, bank index and write data. During a valid read it returns the selected bank's data onto a tri-state data bus. The block also combines the banks' interrupt requests into an open-drain pull-down enable. A rising edge on the hardware reset pin becomes a single clear pulse for the configuration registers.

The state machine has six states. IDLE waits for a strobe. From IDLE, a strobe with a valid select goes to RD_START (read) or WR_HOLD (write). A conflicting strobe pair or a bad select goes to BLOCKED. RD_START lasts one cycle and moves to RD_HOLD while the read strobe stays active, or back to IDLE when it has gone. RD_HOLD returns to IDLE when the strobe is released. WR_HOLD moves to WR_DONE when the write strobe is released, and WR_DONE returns to IDLE after one cycle. BLOCKED returns to IDLE once no strobe is active.

Top module: `hostbus_port`

## Requirements
- R1: With `strap_shared`=1, the register address is the value on `ad_in` when `ale_a7` rises. `addr_lo` has no effect on `reg_addr`.
- R2: With `strap_shared`=0, the register address is {`ale_a7`, `addr_lo`} as seen when the strobe becomes active. `ale_a7` is bit 7.
- R3: With `strap_moto`=0, `rd_ds_n`=0 requests a read and `wr_rw`=0 requests a write. Both low together is ignored: there is no strobe and no drive.
- R4: With `strap_moto`=1, `rd_ds_n`=0 is the data strobe. `wr_rw`=1 makes the access a read and `wr_rw`=0 makes it a write.
- R5: Each write access gives exactly one `reg_wr` pulse, one cycle wide, carrying the captured address, bank and data. The pulse is high after the third rising clock edge that follows the strobe release at the pins.
- R6: Each read access gives exactly one `reg_rd` pulse, one cycle wide. The pulse is high after the third rising edge that follows the strobe assertion at the pins.
- R7: `ad_oe` is high only during a valid read while the chosen chip select stays low. While it is high, `ad_out` equals the selected bank's slice of `bank_rdata` (bank b at bits 8b+7..8b).
- R8: When the number of low chip selects is not exactly one, a strobe produces no `reg_rd`, no `reg_wr` and no `ad_oe`.
- R9: `reg_bank` is the index of the low chip select: `cs_n[b]`=0 selects bank b.
- R10: `irq_pull` is high one cycle after any bit of `bank_irq` is set, and low one cycle after all bits are clear. It never drives the line high.
- R11: A rising edge on `hw_reset` gives exactly one `cfg_clear` pulse. The pulse is high after the third rising clock edge that follows the edge at the pin.
- R12: After reset the block is idle: `reg_rd`, `reg_wr`, `ad_oe`, `irq_pull` and `cfg_clear` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap_shared | input | 1 | 1: shared address/data bus; 0: separate buses |
| strap_moto | input | 1 | 1: data strobe plus read/write level; 0: separate read/write strobes |
| cs_n | input | NBANK | Active-low chip select, one per bank |
| rd_ds_n | input | 1 | Read strobe or data strobe, active low |
| wr_rw | input | 1 | Write strobe (active low) or read/write-bar level |
| ale_a7 | input | 1 | Address latch enable (shared) or address bit 7 (separate) |
| addr_lo | input | AW-1 | Low address bits, used only on separate buses |
| ad_in | input | DW | Data bus input, or address/data in shared mode |
| ad_out | output | DW | Read data driven onto the bus |
| ad_oe | output | 1 | Output enable for the data bus |
| reg_rd | output | 1 | Internal register read pulse |
| reg_wr | output | 1 | Internal register write pulse |
| reg_addr | output | AW | Register address of the current access |
| reg_wdata | output | DW | Write data of the current access |
| reg_bank | output | BW | Index of the selected bank |
| bank_rdata | input | NBANK*DW | Read data from every bank, bank b at bits 8b+7..8b |
| bank_irq | input | NBANK | Enabled-status interrupt request per bank |
| irq_pull | output | 1 | Open-drain pull-down enable for the interrupt line |
| hw_reset | input | 1 | Hardware reset pin; a rising edge clears configuration |
| cfg_clear | output | 1 | One-cycle configuration clear pulse |

## Verification
Every pin result lands a fixed number of cycles after the pin change. `reg_rd` and the write pulse are high after the third rising edge that follows the strobe edge, and so is `cfg_clear` after the reset-pin edge. `ad_oe` and `ad_out` are settled by the fourth. `irq_pull` follows `bank_irq` after one edge. The bench drives every pin on a falling edge and samples one time unit after a later falling edge. Dedicated tests step edge by edge and require the pulse in exactly the third cycle. The sweep tests wait four cycles after assertion and five after release before checking the strobe counts, the captured address, data and bank, and the driven read data.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_START,
        S_RD_HOLD,
        S_WR_HOLD,
        S_WR_DONE,
        S_BLOCKED
    } hbp_state_t;

endpackage

// File: rtl/hbp_sync.sv
module hbp_sync #(
    parameter int           W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/hbp_addr_latch.sv
module hbp_addr_latch #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shared,
    input  logic          ale_s,
    input  logic [AW-2:0] lo_s,
    input  logic [DW-1:0] ad_s,
    output logic [AW-1:0] addr_now
);
    logic          ale_q;
    logic [AW-1:0] addr_q;
    logic          ale_rise;

    assign ale_rise = ale_s && !ale_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ale_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            ale_q <= ale_s;
            if (ale_rise) begin
                addr_q <= ad_s[AW-1:0];
            end
        end
    end

    assign addr_now = shared ? addr_q : {ale_s, lo_s};

    // R1
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_rise |=> $stable(addr_q));
endmodule

// File: rtl/hbp_ctrl.sv
module hbp_ctrl
    import hbp_pkg::*;
#(
    parameter int NBANK = 4,
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                moto,
    input  logic                rd_ds_s,
    input  logic                wr_rw_s,
    input  logic [NBANK-1:0]    cs_n_s,
    input  logic [AW-1:0]       addr_now,
    input  logic [DW-1:0]       ad_s,
    input  logic [NBANK*DW-1:0] bank_rdata,
    output logic                reg_rd,
    output logic                reg_wr,
    output logic [AW-1:0]       reg_addr,
    output logic [DW-1:0]       reg_wdata,
    output logic [BW-1:0]       reg_bank,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe
);
    hbp_state_t state, state_nx;

    logic          rd_req, wr_req, any_req, conflict;
    logic          cs_ok;
    logic [BW-1:0] cs_idx;

    always_comb begin
        if (moto) begin
            rd_req = !rd_ds_s && wr_rw_s;
            wr_req = !rd_ds_s && !wr_rw_s;
        end else begin
            rd_req = !rd_ds_s;
            wr_req = !wr_rw_s;
        end
        any_req  = rd_req || wr_req;
        conflict = rd_req && wr_req;
    end

    always_comb begin
        int lows;
        lows   = 0;
        cs_idx = '0;
        for (int i = NBANK - 1; i >= 0; i--) begin
            if (!cs_n_s[i]) begin
                lows   = lows + 1;
                cs_idx = BW'(i);
            end
        end
        cs_ok = (lows == 1);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (any_req) begin
                    if (!cs_ok || conflict) state_nx = S_BLOCKED;
                    else if (wr_req)        state_nx = S_WR_HOLD;
                    else                    state_nx = S_RD_START;
                end
            end
            S_RD_START: state_nx = rd_req ? S_RD_HOLD : S_IDLE;
            S_RD_HOLD:  if (!rd_req) state_nx = S_IDLE;
            S_WR_HOLD:  if (!wr_req) state_nx = S_WR_DONE;
            S_WR_DONE:  state_nx = S_IDLE;
            S_BLOCKED:  if (!any_req) state_nx = S_IDLE;
            default:    state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_addr  <= '0;
            reg_wdata <= '0;
            reg_bank  <= '0;
        end else begin
            if (state == S_IDLE && any_req) begin
                reg_addr <= addr_now;
                reg_bank <= cs_idx;
                reg_wdata <= ad_s;
            end else if (state == S_WR_HOLD && wr_req) begin
                reg_wdata <= ad_s;
            end
        end
    end

    always_comb begin
        reg_rd = (state == S_RD_START);
        reg_wr = (state == S_WR_DONE);
        ad_oe  = (state == S_RD_START || state == S_RD_HOLD)
                 && cs_ok && !cs_n_s[reg_bank];
        ad_out = bank_rdata[reg_bank*DW +: DW];
    end

    // R6
    rd_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> !reg_rd);
    // R5
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> !reg_wr);
    // R8
    rd_valid_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |-> $past(cs_ok));
    // R7
    no_drive_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> !ad_oe);
    // R2
    wr_addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |-> $stable(reg_addr));
endmodule

// File: rtl/hostbus_port.sv
module hostbus_port #(
    parameter int NBANK = 4,
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int BW    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                strap_shared,
    input  logic                strap_moto,
    input  logic [NBANK-1:0]    cs_n,
    input  logic                rd_ds_n,
    input  logic                wr_rw,
    input  logic                ale_a7,
    input  logic [AW-2:0]       addr_lo,
    input  logic [DW-1:0]       ad_in,
    output logic [DW-1:0]       ad_out,
    output logic                ad_oe,
    output logic                reg_rd,
    output logic                reg_wr,
    output logic [AW-1:0]       reg_addr,
    output logic [DW-1:0]       reg_wdata,
    output logic [BW-1:0]       reg_bank,
    input  logic [NBANK*DW-1:0] bank_rdata,
    input  logic [NBANK-1:0]    bank_irq,
    output logic                irq_pull,
    input  logic                hw_reset,
    output logic                cfg_clear
);
    localparam int SW = 4 + NBANK + (AW - 1) + DW;
    localparam logic [SW-1:0] SYNC_RST =
        {1'b0, 1'b0, 1'b1, 1'b1, {NBANK{1'b1}}, {(AW-1){1'b0}}, {DW{1'b0}}};

    logic                hw_s, ale_s, wr_s, rd_s;
    logic [NBANK-1:0]    cs_s;
    logic [AW-2:0]       lo_s;
    logic [DW-1:0]       ad_s;
    logic [AW-1:0]       addr_now;
    logic                hw_q;

    hbp_sync #(.W(SW), .RST_VAL(SYNC_RST)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({hw_reset, ale_a7, wr_rw, rd_ds_n, cs_n, addr_lo, ad_in}),
        .q     ({hw_s, ale_s, wr_s, rd_s, cs_s, lo_s, ad_s})
    );

    hbp_addr_latch #(.AW(AW), .DW(DW)) latch_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shared   (strap_shared),
        .ale_s    (ale_s),
        .lo_s     (lo_s),
        .ad_s     (ad_s),
        .addr_now (addr_now)
    );

    hbp_ctrl #(.NBANK(NBANK), .AW(AW), .DW(DW), .BW(BW)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .moto       (strap_moto),
        .rd_ds_s    (rd_s),
        .wr_rw_s    (wr_s),
        .cs_n_s     (cs_s),
        .addr_now   (addr_now),
        .ad_s       (ad_s),
        .bank_rdata (bank_rdata),
        .reg_rd     (reg_rd),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_bank   (reg_bank),
        .ad_out     (ad_out),
        .ad_oe      (ad_oe)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q      <= 1'b0;
            cfg_clear <= 1'b0;
            irq_pull  <= 1'b0;
        end else begin
            hw_q      <= hw_s;
            cfg_clear <= hw_s && !hw_q;
            irq_pull  <= |bank_irq;
        end
    end

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bank_irq) |=> irq_pull);
    // R10
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq == '0) |=> !irq_pull);
    // R11
    clear_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_clear |=> !cfg_clear);
endmodule

// File: tb/hostbus_port_tb.sv
module hostbus_port_tb_top;
    localparam int NBANK = 4;
    localparam int AW    = 8;
    localparam int DW    = 8;
    localparam int BW    = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_shared = 1'b0, strap_moto = 1'b0;
    logic [NBANK-1:0] cs_n = '1;
    logic rd_ds_n = 1'b1, wr_rw = 1'b1, ale_a7 = 1'b0;
    logic [AW-2:0] addr_lo = '0;
    logic [DW-1:0] ad_in = '0;
    logic [DW-1:0] ad_out;
    logic ad_oe, reg_rd, reg_wr, irq_pull, cfg_clear;
    logic [AW-1:0] reg_addr;
    logic [DW-1:0] reg_wdata;
    logic [BW-1:0] reg_bank;
    logic [NBANK*DW-1:0] bank_rdata;
    logic [NBANK-1:0] bank_irq = '0;
    logic hw_reset = 1'b0;

    int checks = 0, errors = 0;
    int wr_cnt = 0, rd_cnt = 0, clr_cnt = 0;
    logic [7:0] w_addr, w_data;
    int w_bank, r_bank;

    always #5 clk = ~clk;

    hostbus_port #(.NBANK(NBANK), .AW(AW), .DW(DW), .BW(BW)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_shared(strap_shared), .strap_moto(strap_moto),
        .cs_n(cs_n), .rd_ds_n(rd_ds_n), .wr_rw(wr_rw), .ale_a7(ale_a7),
        .addr_lo(addr_lo), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
        .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_bank(reg_bank), .bank_rdata(bank_rdata), .bank_irq(bank_irq),
        .irq_pull(irq_pull), .hw_reset(hw_reset), .cfg_clear(cfg_clear)
    );

    // each bank answers with its address xor 0x11 times its index
    always_comb begin
        for (int b = 0; b < NBANK; b++) bank_rdata[b*DW +: DW] = reg_addr ^ 8'(8'h11 * b);
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_wr) begin
                wr_cnt++; w_addr = reg_addr; w_data = reg_wdata; w_bank = int'(reg_bank);
            end
            if (reg_rd) begin
                rd_cnt++; r_bank = int'(reg_bank);
            end
            if (cfg_clear) clr_cnt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_access(input bit shared, input bit moto, input int b,
                              input logic [7:0] a, input bit is_wr, input logic [7:0] d);
        int w0, r0;
        @(negedge clk);
        strap_shared = shared; strap_moto = moto;
        rd_ds_n = 1'b1; wr_rw = 1'b1; cs_n = '1;
        if (shared) begin
            ad_in = a; addr_lo = ~a[6:0]; ale_a7 = 1'b1;
            tick(3); ale_a7 = 1'b0;
            tick(3); ad_in = is_wr ? d : 8'h00;
        end else begin
            ad_in = is_wr ? d : 8'h00; addr_lo = a[6:0]; ale_a7 = a[7];
        end
        cs_n = ~(NBANK'(1) << b);
        w0 = wr_cnt; r0 = rd_cnt;
        if (moto) begin
            wr_rw = !is_wr; rd_ds_n = 1'b0;
        end else if (is_wr) wr_rw = 1'b0;
        else rd_ds_n = 1'b0;
        tick(4); #1;
        if (is_wr) chk("R7 no drive on write", int'(ad_oe), 0);
        else begin
            chk(moto ? "R4 read oe" : "R3 read oe", int'(ad_oe), 1);
            chk("R7 read data", int'(ad_out), int'(a ^ 8'(8'h11 * b)));
            chk(shared ? "R1 read addr" : "R2 read addr", int'(reg_addr), int'(a));
            chk("R6 one read pulse", rd_cnt, r0 + 1);
            chk("R9 read bank", r_bank, b);
        end
        @(negedge clk);
        rd_ds_n = 1'b1; wr_rw = 1'b1;
        tick(5); #1;
        if (is_wr) begin
            chk(moto ? "R4 one write pulse" : "R5 one write pulse", wr_cnt, w0 + 1);
            chk(shared ? "R1 write addr" : "R2 write addr", int'(w_addr), int'(a));
            chk("R5 write data", int'(w_data), int'(d));
            chk("R9 write bank", w_bank, b);
        end else begin
            chk("R7 oe released", int'(ad_oe), 0);
            chk("R3 no write on read", wr_cnt, w0);
        end
        cs_n = '1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int w0, r0;
        tick(3); #1;
        // R12
        chk("R12 reg_rd", int'(reg_rd), 0);
        chk("R12 reg_wr", int'(reg_wr), 0);
        chk("R12 ad_oe", int'(ad_oe), 0);
        chk("R12 irq_pull", int'(irq_pull), 0);
        chk("R12 cfg_clear", int'(cfg_clear), 0);
        @(negedge clk); rst_n = 1'b1;
        tick(2);

        // sweep: bus layout x strobe style x bank x direction
        for (int cfg = 0; cfg < 4; cfg++)
            for (int b = 0; b < NBANK; b++)
                for (int w = 0; w < 2; w++) begin
                    logic [7:0] a;
                    a = 8'(cfg * 64 + b * 16 + w * 8 + 5);
                    run_access(cfg[1], cfg[0], b, a, w[0], ~a ^ 8'h5A);
                end

        // R5 exact write pulse cycle
        @(negedge clk);
        strap_shared = 0; strap_moto = 0; addr_lo = 7'h12; ale_a7 = 0; ad_in = 8'h33;
        cs_n = 4'b1011; wr_rw = 1'b0;
        tick(5);
        @(negedge clk); wr_rw = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); #1;
            chk("R5 write pulse cycle", int'(reg_wr), (i == 3) ? 1 : 0);
        end
        // R6 exact read pulse cycle
        @(negedge clk); rd_ds_n = 1'b0;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); #1;
            chk("R6 read pulse cycle", int'(reg_rd), (i == 3) ? 1 : 0);
        end
        @(negedge clk); rd_ds_n = 1'b1; cs_n = '1;
        tick(4);

        // R8 no select, two selects, R3 both strobes low
        w0 = wr_cnt; r0 = rd_cnt;
        @(negedge clk); cs_n = 4'b1111; wr_rw = 1'b0;
        tick(4); @(negedge clk); wr_rw = 1'b1; tick(5); #1;
        chk("R8 no select no write", wr_cnt, w0);
        @(negedge clk); cs_n = 4'b1010; rd_ds_n = 1'b0;
        tick(4); #1;
        chk("R8 two selects no drive", int'(ad_oe), 0);
        @(negedge clk); rd_ds_n = 1'b1; tick(5); #1;
        chk("R8 two selects no read", rd_cnt, r0);
        @(negedge clk); cs_n = 4'b0111; rd_ds_n = 1'b0; wr_rw = 1'b0;
        tick(4); #1;
        chk("R3 conflict no drive", int'(ad_oe), 0);
        @(negedge clk); rd_ds_n = 1'b1; wr_rw = 1'b1; tick(5); #1;
        chk("R3 conflict no write", wr_cnt, w0);
        chk("R3 conflict no read", rd_cnt, r0);
        cs_n = '1;

        // R10 interrupt combine, one cycle
        for (int v = 0; v < 16; v++) begin
            @(negedge clk); bank_irq = 4'(v);
            @(negedge clk); #1;
            chk("R10 irq_pull", int'(irq_pull), (v != 0) ? 1 : 0);
        end
        @(negedge clk); bank_irq = '0;

        // R11 clear pulse
        @(negedge clk); hw_reset = 1'b1;
        for (int i = 1; i <= 4; i++) begin
            @(negedge clk); #1;
            chk("R11 clear cycle", int'(cfg_clear), (i == 3) ? 1 : 0);
        end
        tick(4); #1;
        chk("R11 one clear pulse", clr_cnt, 1);
        @(negedge clk); hw_reset = 1'b0; tick(6); #1;
        chk("R11 no clear on fall", clr_cnt, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule